// File: doc/BRIEF.md
# Unaligned Load Alignment Unit

This unit sits between a load pipeline and a 32-bit little-endian memory that accepts only word-aligned read addresses. It takes byte, halfword and word load requests at any byte address. If every requested byte lies inside one aligned word, it issues one aligned read and moves the wanted bytes down to the low end of the result. If the bytes run past the end of that word, it reads the aligned word at the base and then the next one at base+4. It then joins the bytes, with those from the lower word in the low positions of the result.

Byte and halfword results are sign-extended or zero-extended according to the request's signed flag. The finished value comes out with a one-cycle done strobe. The unit holds one request at a time: it takes a new request only when idle, and it keeps request-ready low until the result has been delivered. An access that crosses a word boundary needs two bus operations, so it completes later than an access that does not.

Top module: `unaligned_load_unit`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and rsp_done is 0.
- R2: Every address presented on mem_addr while mem_req_valid is high has its two low bits equal to zero.
- R3: The size code is 0 for a byte, 1 for a halfword, and 2 or 3 for a word. Let offset be the value of addr[1:0] and n the byte count. When offset+n is at most 4, the unit makes exactly one memory read, at the aligned address addr with its two low bits cleared. Byte loads therefore always make one read.
- R4: When offset+n exceeds 4, the unit makes exactly two memory reads. The first is at the aligned base and the second is at base+4.
- R5: Bit 8*i to 8*i+7 of rsp_data, for i below n, is the memory byte at address addr+i. Byte addresses within a word are little-endian: byte k of a word sits at bits 8*k to 8*k+7.
- R6: For a byte or halfword load, the bits of rsp_data above the loaded bytes are all copies of the loaded value's top bit when req_signed is 1. They are all zero when req_signed is 0. Word loads return all 32 bits as read.
- R7: From the cycle after a request is accepted until rsp_done is high, req_ready stays 0.
- R8: rsp_done is high for exactly one cycle, and that cycle is the one right after the final memory response is accepted.
- R9: While mem_req_valid is high and mem_req_ready is low, mem_req_valid and mem_addr hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit is idle and takes a request |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_signed | input | 1 | Sign-extend byte and halfword results |
| mem_req_valid | output | 1 | Aligned read request to memory |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_addr | output | ADDR_W | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Read data word |
| rsp_done | output | 1 | One-cycle strobe: result valid |
| rsp_data | output | 32 | Aligned and extended load result |

## Verification
The result is due in the cycle right after the memory model drives the final response. The bench samples at falling edges, so it looks for rsp_done and rsp_data at the falling edge after the one where it drove that response, and it checks that the strobe has gone low one falling edge later. The memory model is stepped at the same falling edges. It counts read handshakes and logs their addresses, and it inserts random ready stalls and random response delays of one to three cycles, so each request's read count and addresses are compared only once its result has arrived. While a request is in flight, req_ready is sampled at every falling edge up to the done cycle.

// File: rtl/ulu_pkg.sv
package ulu_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    LD_BYTE = 2'd0,
    LD_HALF = 2'd1,
    LD_WORD = 2'd2,
    LD_WRD3 = 2'd3
  } ld_size_e;

  // Number of bytes a load of this size touches.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // True when the bytes of the load run past the end of the aligned word.
  function automatic logic crosses_word(input logic [OFF_W-1:0] off,
                                        input logic [1:0] sz);
    logic [3:0] last_excl;
    last_excl    = 4'(off) + 4'(size_bytes(sz));
    crosses_word = last_excl > 4'(WORD_BYTES);
  endfunction

  // Width extension of the low-aligned value according to size and sign.
  function automatic logic [WORD_W-1:0] extend(input logic [WORD_W-1:0] raw,
                                               input logic [1:0] sz,
                                               input logic sgn);
    case (sz)
      2'd0:    extend = {{24{sgn & raw[7]}}, raw[7:0]};
      2'd1:    extend = {{16{sgn & raw[15]}}, raw[15:0]};
      default: extend = raw;
    endcase
  endfunction
endpackage

// File: rtl/ulu_split_detect.sv
module ulu_split_detect
  import ulu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] base_lo,
  output logic [ADDR_W-1:0] base_hi,
  output logic [OFF_W-1:0]  offset,
  output logic              split
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

  always_comb begin
    offset  = addr[OFF_W-1:0];
    base_lo = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    base_hi = base_lo + STRIDE;
    split   = crosses_word(offset, size);
  end
endmodule

// File: rtl/ulu_read_seq.sv
module ulu_read_seq
  import ulu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              split_in,
  input  logic [ADDR_W-1:0] base_lo_in,
  input  logic [ADDR_W-1:0] base_hi_in,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  output logic              cap_lo,
  output logic              finish,
  output logic              busy
);
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ASK0  = 3'd1,
    SQ_WAIT0 = 3'd2,
    SQ_ASK1  = 3'd3,
    SQ_WAIT1 = 3'd4
  } seq_state_e;

  seq_state_e        st_q;
  logic              split_q;
  logic [ADDR_W-1:0] a0_q, a1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      split_q <= 1'b0;
      a0_q    <= '0;
      a1_q    <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start) begin
          st_q    <= SQ_ASK0;
          split_q <= split_in;
          a0_q    <= base_lo_in;
          a1_q    <= base_hi_in;
        end
        SQ_ASK0:  if (mem_req_ready) st_q <= SQ_WAIT0;
        SQ_WAIT0: if (mem_rsp_valid) st_q <= split_q ? SQ_ASK1 : SQ_IDLE;
        SQ_ASK1:  if (mem_req_ready) st_q <= SQ_WAIT1;
        SQ_WAIT1: if (mem_rsp_valid) st_q <= SQ_IDLE;
        default:  st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (st_q == SQ_ASK0) || (st_q == SQ_ASK1);
    mem_addr      = (st_q == SQ_ASK1) ? a1_q : a0_q;
    cap_lo        = (st_q == SQ_WAIT0) && mem_rsp_valid && split_q;
    finish        = ((st_q == SQ_WAIT0) && mem_rsp_valid && !split_q) ||
                    ((st_q == SQ_WAIT1) && mem_rsp_valid);
    busy          = (st_q != SQ_IDLE);
  end

  // R2
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_addr[OFF_W-1:0] == '0));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
endmodule

// File: rtl/ulu_byte_merge.sv
module ulu_byte_merge
  import ulu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [1:0]        size_in,
  input  logic              sgn_in,
  input  logic              split_in,
  input  logic              cap_lo,
  input  logic              finish,
  input  logic [WORD_W-1:0] rsp_word,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  localparam int WIN_BYTES = 2 * WORD_BYTES;
  localparam int IDX_W     = $clog2(WIN_BYTES);

  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              sgn_q, split_q;
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] lo_w, hi_w, shifted;
  logic [7:0]        win_b [WIN_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= '0;
      size_q  <= '0;
      sgn_q   <= 1'b0;
      split_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      if (start) begin
        off_q   <= off_in;
        size_q  <= size_in;
        sgn_q   <= sgn_in;
        split_q <= split_in;
      end
      if (cap_lo) lo_q <= rsp_word;
    end
  end

  always_comb begin
    lo_w = split_q ? lo_q : rsp_word;
    hi_w = rsp_word;
  end

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_win
    assign win_b[b]              = lo_w[8*b +: 8];
    assign win_b[b + WORD_BYTES] = hi_w[8*b +: 8];
  end

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    assign shifted[8*i +: 8] = win_b[IDX_W'(off_q) + IDX_W'(i)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= finish;
      if (finish) result <= extend(shifted, size_q, sgn_q);
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit
  import ulu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              rsp_done,
  output logic [31:0]       rsp_data
);
  logic [ADDR_W-1:0] base_lo, base_hi;
  logic [OFF_W-1:0]  offset;
  logic              split, accept, cap_lo, finish, busy;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  ulu_split_detect #(.ADDR_W(ADDR_W)) split_i (
    .addr    (req_addr),
    .size    (req_size),
    .base_lo (base_lo),
    .base_hi (base_hi),
    .offset  (offset),
    .split   (split)
  );

  ulu_read_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .split_in      (split),
    .base_lo_in    (base_lo),
    .base_hi_in    (base_hi),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .cap_lo        (cap_lo),
    .finish        (finish),
    .busy          (busy)
  );

  ulu_byte_merge merge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .off_in   (offset),
    .size_in  (req_size),
    .sgn_in   (req_signed),
    .split_in (split),
    .cap_lo   (cap_lo),
    .finish   (finish),
    .rsp_word (mem_rsp_data),
    .done     (rsp_done),
    .result   (rsp_data)
  );

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  done_follows_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(mem_rsp_valid));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (req_ready && !mem_req_valid && !rsp_done));
endmodule

// File: tb/unaligned_load_unit_tb_top.sv
module unaligned_load_unit_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_signed = 1'b0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          rsp_done;
  logic [31:0]   rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  int rd_total = 0;
  logic [AW-1:0] rd_log [2048];
  int pend = 0;
  logic [AW-1:0] pend_addr = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  unaligned_load_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    logic [15:0] t;
    t = a * 16'd29 + (a >> 4) * 16'd7 + 16'h5B;
    return t[7:0] ^ {a[2:0], 5'b0};
  endfunction

  function automatic logic [31:0] mword(input logic [AW-1:0] a);
    return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expect_val(input logic [AW-1:0] a,
                                             input logic [1:0] sz, input bit sg);
    logic [31:0] v;
    int n;
    n = nbytes(sz);
    v = '0;
    for (int i = 0; i < n; i++) v[i*8 +: 8] = mbyte(a + AW'(i));
    if (sg && v[n*8-1])
      for (int j = n * 8; j < 32; j++) v[j] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model and done-timing monitor, stepped at falling edges.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        pend = 0;
      end else begin
        // R8: done must follow the response driven one edge earlier
        if (rsp_done) chk(mem_rsp_valid, "R8", "done without prior response",
                          32'(mem_rsp_valid), 32'd1);
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mword(pend_addr);
          end
        end
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
          rd_log[rd_total % 2048] = mem_addr;
          rd_total++;
          pend = 1 + int'($urandom % 3);
          pend_addr = mem_addr;
        end
      end
    end
  end

  task automatic do_load(input logic [AW-1:0] a, input logic [1:0] sz, input bit sg);
    int r0, nrd, waitc;
    bit busy_bad, split;
    logic [AW-1:0] base;
    logic [31:0] exp;
    @(negedge clk);
    r0 = rd_total;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_signed = sg;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 0;
    waitc = 0;
    while (!rsp_done && waitc < 50) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      waitc++;
    end
    exp = expect_val(a, sz, sg);
    chk(rsp_done, "R8", "done never seen", 32'(rsp_done), 32'd1);
    chk(!busy_bad, "R7", "req_ready high while busy", 32'(busy_bad), 32'd0);
    if (sz >= 2'd2) chk(rsp_data == exp, "R5", "word data", rsp_data, exp);
    else chk(rsp_data == exp, "R6", "extended data", rsp_data, exp);
    nrd = rd_total - r0;
    base = {a[AW-1:2], 2'b00};
    split = (int'(a[1:0]) + nbytes(sz)) > 4;
    if (split) begin
      chk(nrd == 2, "R4", "read count", 32'(nrd), 32'd2);
      chk(rd_log[r0 % 2048] == base && rd_log[(r0 + 1) % 2048] == base + AW'(4),
          "R4", "read addresses", {rd_log[r0 % 2048], rd_log[(r0 + 1) % 2048]},
          {base, base + AW'(4)});
    end else begin
      chk(nrd == 1, "R3", "read count", 32'(nrd), 32'd1);
      chk(rd_log[r0 % 2048] == base, "R3", "read address",
          32'(rd_log[r0 % 2048]), 32'(base));
    end
    chk(rd_log[r0 % 2048][1:0] == 2'b00, "R2", "aligned address",
        32'(rd_log[r0 % 2048]), 32'(base));
    @(negedge clk);
    chk(!rsp_done, "R8", "done longer than one cycle", 32'(rsp_done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_done, "R1", "reset outputs",
        {29'd0, req_ready, mem_req_valid, rsp_done}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_done, "R1", "idle after reset",
        {29'd0, req_ready, mem_req_valid, rsp_done}, 32'd4);
    // Directed corner cases
    do_load(16'h0101, 2'd1, 1'b0);  // R3 half at offset 1, one read
    do_load(16'h0103, 2'd1, 1'b1);  // R4 half at offset 3, two reads
    do_load(16'h0101, 2'd2, 1'b0);  // R4 word offset 1
    do_load(16'h0102, 2'd2, 1'b0);  // R4 word offset 2
    do_load(16'h0107, 2'd3, 1'b0);  // R4 word offset 3, size code 3
    do_load(16'h0200, 2'd2, 1'b0);  // R3 aligned word
    do_load(16'h0203, 2'd0, 1'b1);  // R3 byte offset 3
    do_load(16'h0202, 2'd1, 1'b1);  // R3 half offset 2
    for (int a = 0; a < 16; a++) begin
      do_load(AW'(16'h0300 + a), 2'd0, 1'b1);  // R6 signed bytes
      do_load(AW'(16'h0300 + a), 2'd1, 1'b0);  // R6 unsigned halves
    end
    for (int k = 0; k < 300; k++)
      do_load(AW'($urandom % 4096), 2'($urandom % 4), 1'($urandom % 2));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule